// File: doc/BRIEF.md
# Prescaled Bus Wait-Timeout Timer

This block watches a master transfer on a two-wire serial bus for a stall. The master engine raises a qualifier while it is waiting on the clock line. For as long as that qualifier stays high, the block counts down a programmed limit at a slow tick rate. If the limit runs out, it raises a timeout flag. The flag is kept apart from every other error the controller reports. It holds until software clears it with a one-cycle pulse.

Two configuration fields set the timing. The first is a 4-bit prescale exponent: one tick comes every 2^s system clocks. The second is a 16-bit control word with the enable in bit 15 and the count limit in bits 14:0. Because the enable and the count share one word, software can switch the timer off and back on by flipping bit 15 alone, and the stored limit is kept. The timer restarts from the full limit each time the wait ends, each time a new transfer starts and each time it is disabled. Disabling it also clears the prescale divider, so the first tick after a restart always comes a whole period later.

Top module: `bus_wait_timer`

## Requirements
- R1: After reset `timeout_o` is low. No expiry can happen until a reload has occurred. A reload is a cycle in which the enable bit is low, `bus_wait_i` is low or `xfer_start_i` is high.
- R2: The enable is bit 15 of `cfg_ctrl_i` and the limit N is bits 14:0. With the enable set and `bus_wait_i` held high after a reload, `timeout_o` rises at the clock edge that ends waiting cycle (N+1)·2^s, and not before.
- R3: A limit of zero expires on the first divided tick: after 2^s waiting cycles.
- R4: `cfg_shift_i` values above 14 act as 14.
- R5: While bit 15 of `cfg_ctrl_i` is low, `timeout_o` never rises, whatever `bus_wait_i` does.
- R6: Clearing bit 15 for one cycle and then rewriting the same word with bit 15 set re-arms the timer. A full (N+1)·2^s period is needed again, because the divider restarts.
- R7: One cycle with `bus_wait_i` low reloads the count, and a full period is needed again.
- R8: A `xfer_start_i` pulse reloads the count while waiting, and a full period is needed again.
- R9: `timeout_o` stays high until a `timeout_clr_i` pulse, whether or not the bus is still waiting.
- R10: After an expiry, `timeout_o` is not set again until a reload has occurred, even if it is cleared while waiting continues.
- R11: When a clear pulse and a new expiry fall in the same cycle, `timeout_o` ends up high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_shift_i | input | 4 | Prescale exponent s; tick every 2^s clocks (clamped to 14) |
| cfg_ctrl_i | input | 16 | Bit 15 enable, bits 14:0 count limit |
| bus_wait_i | input | 1 | Master engine is waiting on the clock line |
| xfer_start_i | input | 1 | Pulse at the start of a new transfer |
| timeout_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| timeout_o | output | 1 | Sticky timeout status |

## Verification
The hardest state to reach is a flag that software has cleared while the bus is still stalled. In that state the counter is spent but has not been reloaded, so no new timeout must appear until the wait ends. The bench reaches it on purpose. It lets a short period expire, keeps the wait high, pulses the clear and then watches for many more periods. It then lets one more expiry land in the same cycle as a clear pulse. Random segments add clear pulses and start pulses during waits, and a cycle-by-cycle model in the bench checks the flag in every cycle. A run at the largest exponent, with the exponent input set above its legal range, covers the clamp.

// File: rtl/bwt_pkg.sv
`timescale 1ns/1ps
package bwt_pkg;
    localparam int CNT_W_DEF     = 15;
    localparam int SHIFT_W_DEF   = 4;
    localparam int MAX_SHIFT_DEF = 14;
endpackage

// File: rtl/bwt_prescale.sv
`timescale 1ns/1ps
// Power-of-two tick divider; cleared whenever counting is suspended.
module bwt_prescale #(
    parameter int SHIFT_W   = bwt_pkg::SHIFT_W_DEF,
    parameter int MAX_SHIFT = bwt_pkg::MAX_SHIFT_DEF,
    localparam int DIV_W    = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               tick_o
);
    localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] term;

    always_comb begin
        span   = (ONE << shift_i) - ONE;
        term   = span[DIV_W-1:0];
        tick_o = run_i && (s_q.div == term);
        s_d    = s_q;
        if (!run_i || tick_o) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a suspended divider restarts from zero
    a_r6_div_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (s_q.div == '0));
endmodule

// File: rtl/bwt_countdown.sv
`timescale 1ns/1ps
// Limit countdown with a one-shot arm bit.
module bwt_countdown #(
    parameter int CNT_W = bwt_pkg::CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reload_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cd_state_t;

    cd_state_t s_d, s_q;

    always_comb begin
        expire_o = tick_i && !reload_i && s_q.armed && (s_q.cnt == '0);
        s_d      = s_q;
        if (reload_i) begin
            s_d.cnt   = limit_i;
            s_d.armed = 1'b1;
        end else if (tick_i) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end else begin
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: a reload cycle leaves the programmed limit in the counter
    a_r7_reload_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_i |=> (s_q.cnt == $past(limit_i)));

    // R2: every divided tick while armed removes exactly one unit
    a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !reload_i && (s_q.cnt != '0)) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));
endmodule

// File: rtl/bus_wait_timer.sv
`timescale 1ns/1ps
module bus_wait_timer #(
    parameter int CNT_W     = bwt_pkg::CNT_W_DEF,
    parameter int SHIFT_W   = bwt_pkg::SHIFT_W_DEF,
    parameter int MAX_SHIFT = bwt_pkg::MAX_SHIFT_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [SHIFT_W-1:0] cfg_shift_i,
    input  logic [CNT_W:0]     cfg_ctrl_i,
    input  logic               bus_wait_i,
    input  logic               xfer_start_i,
    input  logic               timeout_clr_i,
    output logic               timeout_o
);
    localparam logic [SHIFT_W-1:0] SHIFT_CAP = SHIFT_W'(MAX_SHIFT);

    typedef struct packed {
        logic flag;
    } top_state_t;

    top_state_t         s_d, s_q;
    logic               enable;
    logic [CNT_W-1:0]   limit;
    logic [SHIFT_W-1:0] shift_c;
    logic               reload;
    logic               tick;
    logic               expire;

    always_comb begin
        enable  = cfg_ctrl_i[CNT_W];
        limit   = cfg_ctrl_i[CNT_W-1:0];
        shift_c = (cfg_shift_i > SHIFT_CAP) ? SHIFT_CAP : cfg_shift_i;
        reload  = !enable || !bus_wait_i || xfer_start_i;
    end

    bwt_prescale #(
        .SHIFT_W   (SHIFT_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_prescale (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (!reload),
        .shift_i (shift_c),
        .tick_o  (tick)
    );

    bwt_countdown #(
        .CNT_W (CNT_W)
    ) u_countdown (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .reload_i (reload),
        .tick_i   (tick),
        .limit_i  (limit),
        .expire_o (expire)
    );

    always_comb begin
        s_d      = s_q;
        s_d.flag = (s_q.flag && !timeout_clr_i) || expire;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign timeout_o = s_q.flag;

    // R9: the flag only drops through a clear pulse
    a_r9_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.flag && !timeout_clr_i) |=> s_q.flag);

    // R5: a disabled timer never raises the flag
    a_r5_off_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable && !s_q.flag) |=> !s_q.flag);
endmodule

// File: tb/bus_wait_timer_tb.sv
`timescale 1ns/1ps
module bus_wait_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  shift = '0;
    logic [15:0] ctrl = '0;
    logic        bwait = 1'b0;
    logic        start = 1'b0;
    logic        clr = 1'b0;
    logic        tmo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_wc;
    bit m_armed;
    bit m_flag;

    always #5 clk = ~clk;

    bus_wait_timer u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cfg_shift_i   (shift),
        .cfg_ctrl_i    (ctrl),
        .bus_wait_i    (bwait),
        .xfer_start_i  (start),
        .timeout_clr_i (clr),
        .timeout_o     (tmo)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: timeout_o=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Expiry point in waiting cycles, from R2 and R4
    function automatic int period(input logic [3:0] s, input logic [14:0] n);
        int e;
        e = (s > 4'd14) ? 14 : int'(s);
        return (int'(n) + 1) << e;
    endfunction

    // Waiting-cycle model: counts qualified cycles since the last reload
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wc    = 0;
            m_armed = 1'b0;
            m_flag  = 1'b0;
        end else begin
            bit rl;
            bit fire;
            rl   = !ctrl[15] || !bwait || start;
            fire = !rl && m_armed && (m_wc + 1 == period(shift, ctrl[14:0]));
            if (rl) begin
                m_wc    = 0;
                m_armed = 1'b1;
            end else begin
                m_wc++;
                if (fire) m_armed = 1'b0;
            end
            m_flag = (m_flag && !clr) || fire;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) chk(tmo, m_flag, "R2 per-cycle model");
    end

    task automatic arm(input int s, input int n);
        @(negedge clk);
        bwait = 1'b0; start = 1'b0; clr = 1'b0;
        shift = 4'(s);
        ctrl  = {1'b0, 15'(n)};
        @(negedge clk);
        ctrl[15] = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_for(input int t, input string req);
        bwait = 1'b1;
        repeat (t - 1) @(negedge clk);
        chk(tmo, 1'b0, req);
        @(negedge clk);
        chk(tmo, 1'b1, req);
    endtask

    task automatic clear_flag();
        bwait = 1'b0;
        clr   = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(tmo, 1'b0, "R9 clear pulse");
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        shift = 4'd0;
        ctrl  = {1'b1, 15'd0};
        bwait = 1'b1;
        repeat (3) @(negedge clk);
        chk(tmo, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(tmo, 1'b0, "R1 no expiry before reload");
        bwait = 1'b0;

        arm(2, 3);
        wait_for(16, "R2 N=3 s=2");
        clear_flag();

        arm(0, 0);
        wait_for(1, "R3 zero limit s=0");
        clear_flag();
        arm(3, 0);
        wait_for(8, "R3 zero limit s=3");
        clear_flag();

        arm(15, 0);
        wait_for(16384, "R4 exponent clamp");
        clear_flag();

        arm(0, 0);
        ctrl[15] = 1'b0;
        bwait = 1'b1;
        repeat (20) @(negedge clk);
        chk(tmo, 1'b0, "R5 disabled");
        bwait = 1'b0;

        arm(1, 4);
        bwait = 1'b1;
        repeat (7) @(negedge clk);
        ctrl[15] = 1'b0;
        @(negedge clk);
        ctrl[15] = 1'b1;
        wait_for(10, "R6 re-enable same word");
        clear_flag();

        arm(1, 4);
        bwait = 1'b1;
        repeat (8) @(negedge clk);
        bwait = 1'b0;
        @(negedge clk);
        wait_for(10, "R7 wait dropped");
        clear_flag();

        arm(1, 4);
        bwait = 1'b1;
        repeat (8) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_for(10, "R8 start pulse");
        clear_flag();

        arm(0, 2);
        wait_for(3, "R9 expiry");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(tmo, 1'b1, "R9 sticky while waiting");
        end
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(tmo, 1'b0, "R10 cleared mid-wait");
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(tmo, 1'b0, "R10 no re-set without reload");
        end
        bwait = 1'b0;
        @(negedge clk);
        wait_for(3, "R10 sets after reload");
        bwait = 1'b0;
        @(negedge clk);
        chk(tmo, 1'b1, "R9 sticky after wait ends");
        bwait = 1'b1;
        repeat (2) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(tmo, 1'b1, "R11 clear meets expiry");
        clear_flag();

        for (int t = 0; t < 250; t++) begin
            arm(int'($urandom_range(0, 3)), int'($urandom_range(0, 6)));
            for (int c = 0; c < 40; c++) begin
                bwait = ($urandom_range(0, 99) < 88);
                start = ($urandom_range(0, 99) < 3);
                clr   = ($urandom_range(0, 99) < 8);
                @(negedge clk);
            end
            bwait = 1'b0; start = 1'b0; clr = 1'b0;
        end

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: run still active, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule